// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block sits on the result bus of an analog-to-digital converter and inspects every 12-bit conversion result when it appears. It compares the upper ten bits of each result against a programmed 10-bit threshold. The two least significant bits are dropped as noise. One condition bit selects between an "at or above" test and a "strictly below" test. A result that meets the selected condition sets a sticky flag. When the interrupt enable is set, that flag also raises the interrupt line.

Results from the scan path and the priority path pass through the same comparator. The comparison happens before a result is stored in any FIFO, so a result that will be dropped because its FIFO is full is still checked. Software clears the flag by writing 0 to it. Writing 1 does nothing. A read-modify-write read of the flag returns 1, so that writing the read value back cannot clear a flag that was set while the read was in progress.

Top module: `adc_result_cmp`

## Requirements
- R1: While `cmpEnable` is 0, no result sets `cmpFlag`, whatever its value or the test mode.
- R2: Only result bits 11:2 take part in the comparison. Bits 1:0 never change whether a result counts as a hit.
- R3: With `atOrAbove` = 1, a result is a hit when bits 11:2 are greater than or equal to `threshold`. Equality counts as a hit.
- R4: With `atOrAbove` = 0, a result is a hit when bits 11:2 are strictly less than `threshold`. Equality is not a hit.
- R5: Results are compared the same way whatever `resPath` is (0 = scan, 1 = priority) and whatever `dstFull` is (1 = destination FIFO full).
- R6: A hit on a cycle where `resValid` = 1 sets `cmpFlag` on the next clock edge. The flag then stays set through later results that are not hits.
- R7: `cmpIrq` is 1 exactly when `cmpFlag` is 1 and `intEnable` is 1.
- R8: A write (`flagWrEn` = 1) with `flagWrData` = 0 clears `cmpFlag` on the next edge. A write with `flagWrData` = 1 leaves the flag unchanged.
- R9: `flagRead` returns 1 while `rmwRead` = 1. Otherwise it returns `cmpFlag`.
- R10: When a hit and a clearing write arrive in the same cycle, `cmpFlag` is 1 afterwards.
- R11: After reset, `cmpFlag` and `cmpIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Conversion result strobe |
| resData | input | 12 | Conversion result |
| resPath | input | 1 | Result source: 0 scan, 1 priority |
| dstFull | input | 1 | Destination FIFO is full |
| cmpEnable | input | 1 | Comparator enable |
| atOrAbove | input | 1 | Test mode: 1 at-or-above, 0 below |
| threshold | input | 10 | Threshold for result bits 11:2 |
| intEnable | input | 1 | Interrupt enable |
| flagWrEn | input | 1 | Write strobe for the flag |
| flagWrData | input | 1 | Written flag value (0 clears) |
| rmwRead | input | 1 | Read is part of a read-modify-write |
| cmpFlag | output | 1 | Sticky comparison flag |
| cmpIrq | output | 1 | Comparison interrupt |
| flagRead | output | 1 | Flag value as seen by a read |

## Verification
The threshold is fixed at 100, and results are placed just below it, exactly on it and just above it. In each case the low two bits are set to all-ones or all-zeros, so that a design that compares the full 12 bits gives a different answer from one that drops bits 1:0. The same equality result is applied in both test modes, which separates `>=` from `>` and `<` from `<=`. Hits are also sent with the priority path selected and the FIFO marked full, a hit is sent together with a clearing write, and writes of 1 and 0 are issued to show which write value clears the flag.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic eval;   // a result is present and the comparator is on
    logic clear;  // software clearing write this cycle
  } cmpStrobes_t;
endpackage

// File: rtl/adc_cmp_ctrl.sv
module adc_cmp_ctrl
  import adc_cmp_pkg::*;
(
  input  logic        resValid,
  input  logic        cmpEnable,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  output cmpStrobes_t strb
);
  always_comb begin
    strb.eval  = resValid & cmpEnable;             // R1
    strb.clear = flagWrEn & ~flagWrData;           // R8
  end
endmodule

// File: rtl/adc_cmp_datapath.sv
module adc_cmp_datapath
  import adc_cmp_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int THR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] resData,
  input  logic [THR_W-1:0] threshold,
  input  logic             atOrAbove,
  input  cmpStrobes_t      strb,
  output logic             cmpHit,
  output logic             cmpFlag
);
  localparam int DROP = RES_W - THR_W;

  // The threshold is scaled to the result width with zero low bits.
  // A full-width compare against it equals a compare of the upper bits.
  logic [RES_W-1:0] thrScaled;
  logic             geThr;

  always_comb begin
    thrScaled = {threshold, {DROP{1'b0}}};
    geThr     = (resData >= thrScaled);
    cmpHit    = atOrAbove ? geThr : ~geThr;          // R3, R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cmpFlag <= 1'b0;    // R11
    else if (strb.eval && cmpHit) cmpFlag <= 1'b1;    // R6, R10: set wins
    else if (strb.clear)          cmpFlag <= 1'b0;    // R8
  end

  assert_equal_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eval && atOrAbove && resData[RES_W-1:DROP] == threshold) |=> cmpFlag);

  assert_equal_misses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmpFlag && strb.eval && !atOrAbove && resData[RES_W-1:DROP] == threshold
     && !strb.clear) |=> !cmpFlag);

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eval && cmpHit && strb.clear) |=> cmpFlag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpFlag && !strb.clear) |=> cmpFlag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clear && !(strb.eval && cmpHit)) |=> !cmpFlag);
endmodule

// File: rtl/adc_result_cmp.sv
module adc_result_cmp
  import adc_cmp_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int THR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resValid,
  input  logic [RES_W-1:0] resData,
  input  logic             resPath,
  input  logic             dstFull,
  input  logic             cmpEnable,
  input  logic             atOrAbove,
  input  logic [THR_W-1:0] threshold,
  input  logic             intEnable,
  input  logic             flagWrEn,
  input  logic             flagWrData,
  input  logic             rmwRead,
  output logic             cmpFlag,
  output logic             cmpIrq,
  output logic             flagRead
);
  cmpStrobes_t strb;
  logic        cmpHit;

  adc_cmp_ctrl u_ctrl (
    .resValid  (resValid),
    .cmpEnable (cmpEnable),
    .flagWrEn  (flagWrEn),
    .flagWrData(flagWrData),
    .strb      (strb)
  );

  adc_cmp_datapath #(.RES_W(RES_W), .THR_W(THR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .resData  (resData),
    .threshold(threshold),
    .atOrAbove(atOrAbove),
    .strb     (strb),
    .cmpHit   (cmpHit),
    .cmpFlag  (cmpFlag)
  );

  assign cmpIrq   = cmpFlag & intEnable;    // R7
  assign flagRead = rmwRead | cmpFlag;      // R9

  // Source path and FIFO fullness never block a hit
  assert_full_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && cmpEnable && cmpHit && (resPath || dstFull)) |=> cmpFlag);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpFlag) |-> $past(resValid && cmpEnable));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmpIrq |-> (intEnable && cmpFlag));
endmodule

// File: tb/tb_adc_result_cmp.sv
module tb_adc_result_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resValid = 1'b0;
  logic [11:0] resData = '0;
  logic        resPath = 1'b0;
  logic        dstFull = 1'b0;
  logic        cmpEnable = 1'b0;
  logic        atOrAbove = 1'b0;
  logic [9:0]  threshold = 10'd100;
  logic        intEnable = 1'b0;
  logic        flagWrEn = 1'b0;
  logic        flagWrData = 1'b0;
  logic        rmwRead = 1'b0;
  logic        cmpFlag, cmpIrq, flagRead;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  adc_result_cmp dut (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Present one result for one cycle; the flag is sampled at the next negedge
  task automatic sendRes(input logic [9:0] up, input logic [1:0] lo,
                         input logic path, input logic full);
    @(negedge clk);
    resValid = 1'b1; resData = {up, lo}; resPath = path; dstFull = full;
    @(negedge clk);
    resValid = 1'b0; resPath = 1'b0; dstFull = 1'b0;
  endtask

  task automatic writeFlag(input logic d);
    @(negedge clk);
    flagWrEn = 1'b1; flagWrData = d;
    @(negedge clk);
    flagWrEn = 1'b0;
  endtask

  task automatic testReset;
    check(cmpFlag, 1'b0, "R11 flag after reset");
    check(cmpIrq, 1'b0, "R11 irq after reset");
  endtask

  task automatic testDisabled;
    cmpEnable = 1'b0; atOrAbove = 1'b1;
    sendRes(10'h3FF, 2'b11, 1'b0, 1'b0);
    check(cmpFlag, 1'b0, "R1 disabled large result");
    atOrAbove = 1'b0;
    sendRes(10'd0, 2'b00, 1'b0, 1'b0);
    check(cmpFlag, 1'b0, "R1 disabled small result");
  endtask

  task automatic testAbove;
    cmpEnable = 1'b1; atOrAbove = 1'b1;
    sendRes(10'd99, 2'b11, 1'b0, 1'b0);
    check(cmpFlag, 1'b0, "R2 R3 99 with low bits set below threshold");
    sendRes(10'd100, 2'b00, 1'b0, 1'b0);
    check(cmpFlag, 1'b1, "R3 equality is hit");
    writeFlag(1'b0);
    sendRes(10'd101, 2'b00, 1'b0, 1'b0);
    check(cmpFlag, 1'b1, "R3 above is hit");
    writeFlag(1'b0);
  endtask

  task automatic testBelow;
    cmpEnable = 1'b1; atOrAbove = 1'b0;
    sendRes(10'd100, 2'b11, 1'b0, 1'b0);
    check(cmpFlag, 1'b0, "R4 equality is not hit");
    sendRes(10'd100, 2'b00, 1'b0, 1'b0);
    check(cmpFlag, 1'b0, "R2 low bits irrelevant at equality");
    sendRes(10'd99, 2'b11, 1'b0, 1'b0);
    check(cmpFlag, 1'b1, "R4 below is hit");
    sendRes(10'd500, 2'b00, 1'b0, 1'b0);
    check(cmpFlag, 1'b1, "R6 flag sticky through miss");
  endtask

  task automatic testWrites;
    writeFlag(1'b1);
    check(cmpFlag, 1'b1, "R8 write 1 no effect");
    writeFlag(1'b0);
    check(cmpFlag, 1'b0, "R8 write 0 clears");
  endtask

  task automatic testPaths;
    atOrAbove = 1'b0;
    sendRes(10'd0, 2'b00, 1'b1, 1'b1);
    check(cmpFlag, 1'b1, "R5 priority path with full FIFO");
    writeFlag(1'b0);
    sendRes(10'd5, 2'b01, 1'b0, 1'b1);
    check(cmpFlag, 1'b1, "R5 scan path with full FIFO");
  endtask

  task automatic testIrqRead;
    intEnable = 1'b0; #1;
    check(cmpIrq, 1'b0, "R7 irq masked");
    intEnable = 1'b1; #1;
    check(cmpIrq, 1'b1, "R7 irq on");
    writeFlag(1'b0);
    check(cmpIrq, 1'b0, "R7 irq drops with flag");
    rmwRead = 1'b1; #1;
    check(flagRead, 1'b1, "R9 rmw read returns 1");
    rmwRead = 1'b0; #1;
    check(flagRead, 1'b0, "R9 plain read returns flag");
  endtask

  task automatic testCollision;
    atOrAbove = 1'b1;
    @(negedge clk);
    resValid = 1'b1; resData = {10'd200, 2'b00};
    flagWrEn = 1'b1; flagWrData = 1'b0;
    @(negedge clk);
    resValid = 1'b0; flagWrEn = 1'b0;
    check(cmpFlag, 1'b1, "R10 hit beats clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset;
    testDisabled;
    testAbove;
    testBelow;
    testWrites;
    testPaths;
    testIrqRead;
    testCollision;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule